// File: doc/BRIEF.md
# Banked Branch Direction Table

This block predicts whether conditional branches are taken. It keeps one 2-bit saturating counter, plus a valid flag, for each of `ENTRIES` positions. The positions are arranged as `ENTRIES/SLOTS` rows of `SLOTS` columns, one column for each instruction slot of a fetch group. A fetch address selects one row. The block then returns a valid flag and a taken hint for every slot of that row in the same cycle, with no clock edge in the path.

When a branch resolves, the update port sends its address and its real outcome. The block then trains the single counter that address maps to. The offset of the index fields inside an address depends on whether 16-bit compressed instructions are enabled. A flush input invalidates every entry at once, and so does the synchronous active-low reset.

Top module: `bht_banked`

## Requirements
- R1: The instruction offset width is OFS = 1 when `COMPRESSED` = 1 and OFS = 2 when `COMPRESSED` = 0. The column is address bits [OFS +: log2(SLOTS)]. The row is the next log2(ENTRIES/SLOTS) bits directly above the column. The entry number is row*SLOTS + column.
- R2: A lookup is combinational on `lkp_pc_i`. Bit s of `lkp_valid_o` and bit s of `lkp_taken_o` describe column s of the selected row.
- R3: `lkp_taken_o[s]` is 1 exactly when that entry is valid and its counter is 2 or 3. An invalid entry never reports taken.
- R4: An update to an invalid entry makes it valid. Its counter becomes 2 (weakly taken) when `upd_taken_i` = 1 and 1 (weakly not-taken) when `upd_taken_i` = 0.
- R5: An update to a valid entry moves its counter up by one when taken and down by one when not taken. The counter saturates at 3 and at 0.
- R6: An update takes effect at the clock edge on which `upd_en_i` is sampled high. A lookup in that same cycle still returns the old state.
- R7: An update changes only the one entry it addresses. A cycle with neither an update nor a flush changes no entry.
- R8: `flush_i` high at a clock edge clears every valid flag. A flush and an update in the same cycle leave the addressed entry invalid.
- R9: `rst_n` low at a clock edge clears every valid flag.
- R10: Address bits outside the row and column fields, including the instruction offset bits, have no effect on either lookup or update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| lkp_pc_i | input | ADDR_W | Fetch address to look up |
| lkp_valid_o | output | SLOTS | Per-slot entry valid |
| lkp_taken_o | output | SLOTS | Per-slot taken hint |
| upd_en_i | input | 1 | Resolved-branch update strobe |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome of the branch |

## Verification
The block can be asked to train an entry and to flush the table in the same cycle. A lookup can also address the entry that is being trained in that same cycle. The bench sets up both collisions directly. It drives an update and a lookup of the same address together, and it checks that the lookup shows the old state and that the new state appears only after the edge. It also raises flush together with an update and checks that the trained entry reads back as invalid. The random phase sometimes raises flush along with an update, for both settings of compressed support, and compares every lookup against a reference model kept in the bench.

// File: rtl/bht_pkg.sv
// Shared types and the counter training rule for the branch table.
// Assumes a 2-bit counter in which the MSB is the taken hint.
package bht_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_TAKEN     = 2'd2;
    localparam ctr_t CTR_WEAK_NOT_TAKEN = 2'd1;
    localparam ctr_t CTR_MAX            = 2'd3;
    localparam ctr_t CTR_MIN            = 2'd0;

    // Next counter value for one trained entry.
    function automatic ctr_t ctr_train(input logic was_valid, input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (!was_valid) begin
            nxt = taken ? CTR_WEAK_TAKEN : CTR_WEAK_NOT_TAKEN;
        end else if (taken) begin
            nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
        end else begin
            nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
        end
        return nxt;
    endfunction

    // Width of the instruction offset field below the slot bits.
    function automatic int unsigned offset_bits(input bit compressed);
        return compressed ? 1 : 2;
    endfunction

endpackage

// File: rtl/bht_index.sv
// Splits an address into a row number and a column (slot) number.
// Assumes the column sits just above the offset bits and the row just above the column.
// SLOT_BITS may be 0 (one slot per row), in which case the column is always 0.
module bht_index #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned OFS       = 1,
    parameter int unsigned SLOT_BITS = 1,
    parameter int unsigned ROW_BITS  = 5,
    localparam int unsigned SLOT_W   = (SLOT_BITS > 0) ? SLOT_BITS : 1
) (
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [ROW_BITS-1:0] row_o,
    output logic [SLOT_W-1:0]   slot_o
);

    // Bits outside the two fields are deliberately dropped.
    logic unused_addr;
    assign unused_addr = ^addr_i;

    generate
        if (SLOT_BITS == 0) begin : g_one_slot
            // Single column: no slot field in the address.
            assign slot_o = '0;
        end else begin : g_multi_slot
            // Column field directly above the instruction offset.
            assign slot_o = addr_i[OFS +: SLOT_BITS];
        end
    endgenerate

    // Row field directly above the column field.
    assign row_o = addr_i[OFS + SLOT_BITS +: ROW_BITS];

endmodule

// File: rtl/bht_cell.sv
// One table entry: a valid flag and a 2-bit saturating counter.
// Assumes clear (reset or flush) has priority over a write in the same cycle.
module bht_cell
    import bht_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic we_i,
    input  logic taken_i,
    output logic vld_o,
    output ctr_t ctr_o
);

    // Hold, clear or train the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            ctr_o <= CTR_MIN;
        end else if (clr_i) begin
            vld_o <= 1'b0;
        end else if (we_i) begin
            vld_o <= 1'b1;
            ctr_o <= ctr_train(vld_o, ctr_o, taken_i);
        end
    end

endmodule

// File: rtl/bht_rowsel.sv
// Chooses one row of the table and forms the per-slot valid and taken outputs.
// Purely combinational; assumes ROWS is a power of two so that every row code is in range.
module bht_rowsel
    import bht_pkg::*;
#(
    parameter int unsigned ROWS  = 32,
    parameter int unsigned SLOTS = 2,
    localparam int unsigned ROW_W = $clog2(ROWS)
) (
    input  logic [ROWS-1:0][SLOTS-1:0]      vld_rows_i,
    input  ctr_t [ROWS-1:0][SLOTS-1:0]      ctr_rows_i,
    input  logic [ROW_W-1:0]                row_i,
    output logic [SLOTS-1:0]                vld_o,
    output logic [SLOTS-1:0]                tkn_o
);

    // Read the selected row; a taken hint needs a valid entry.
    always_comb begin
        vld_o = vld_rows_i[row_i];
        for (int s = 0; s < int'(SLOTS); s++) begin
            tkn_o[s] = vld_rows_i[row_i][s] & ctr_rows_i[row_i][s][1];
        end
    end

endmodule

// File: rtl/bht_banked.sv
// Branch direction table of ENTRIES counters, laid out as ENTRIES/SLOTS rows of SLOTS columns.
// A lookup reads a whole row combinationally; an update trains one entry at the clock edge.
// Assumes SLOTS and ENTRIES/SLOTS are powers of two and ENTRIES/SLOTS >= 2.
module bht_banked
    import bht_pkg::*;
#(
    parameter int unsigned ENTRIES    = 64,
    parameter int unsigned SLOTS      = 2,
    parameter int unsigned ADDR_W     = 32,
    parameter bit          COMPRESSED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] lkp_pc_i,
    output logic [SLOTS-1:0]  lkp_valid_o,
    output logic [SLOTS-1:0]  lkp_taken_o,
    input  logic              upd_en_i,
    input  logic [ADDR_W-1:0] upd_pc_i,
    input  logic              upd_taken_i
);

    localparam int unsigned ROWS      = ENTRIES / SLOTS;
    localparam int unsigned OFS       = offset_bits(COMPRESSED);
    localparam int unsigned SLOT_BITS = $clog2(SLOTS);
    localparam int unsigned ROW_BITS  = $clog2(ROWS);
    localparam int unsigned SLOT_W    = (SLOT_BITS > 0) ? SLOT_BITS : 1;

    logic [ROW_BITS-1:0] lkp_row, upd_row;
    logic [SLOT_W-1:0]   lkp_slot, upd_slot;

    logic [ROWS-1:0][SLOTS-1:0] vld_rows;
    ctr_t [ROWS-1:0][SLOTS-1:0] ctr_rows;

    // Flat views of the stored state, used by the bound checker.
    logic [ENTRIES-1:0] vld_q;
    ctr_t [ENTRIES-1:0] ctr_q;
    assign vld_q = vld_rows;
    assign ctr_q = ctr_rows;

    // The lookup column is not needed: the whole row is returned.
    logic unused_lkp_slot;
    assign unused_lkp_slot = ^lkp_slot;

    bht_index #(
        .ADDR_W(ADDR_W), .OFS(OFS), .SLOT_BITS(SLOT_BITS), .ROW_BITS(ROW_BITS)
    ) u_lkp_idx (
        .addr_i(lkp_pc_i), .row_o(lkp_row), .slot_o(lkp_slot)
    );

    bht_index #(
        .ADDR_W(ADDR_W), .OFS(OFS), .SLOT_BITS(SLOT_BITS), .ROW_BITS(ROW_BITS)
    ) u_upd_idx (
        .addr_i(upd_pc_i), .row_o(upd_row), .slot_o(upd_slot)
    );

    generate
        for (genvar r = 0; r < int'(ROWS); r++) begin : g_row
            for (genvar s = 0; s < int'(SLOTS); s++) begin : g_col
                logic hit;
                // Write strobe for this entry: row and column both match.
                if (SLOT_BITS == 0) begin : g_we1
                    assign hit = upd_en_i && (upd_row == ROW_BITS'(r));
                end else begin : g_wen
                    assign hit = upd_en_i && (upd_row == ROW_BITS'(r)) && (upd_slot == SLOT_W'(s));
                end

                bht_cell u_cell (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .clr_i   (flush_i),
                    .we_i    (hit),
                    .taken_i (upd_taken_i),
                    .vld_o   (vld_rows[r][s]),
                    .ctr_o   (ctr_rows[r][s])
                );
            end
        end
    endgenerate

    bht_rowsel #(
        .ROWS(ROWS), .SLOTS(SLOTS)
    ) u_rowsel (
        .vld_rows_i (vld_rows),
        .ctr_rows_i (ctr_rows),
        .row_i      (lkp_row),
        .vld_o      (lkp_valid_o),
        .tkn_o      (lkp_taken_o)
    );

endmodule

// File: rtl/bht_banked_chk.sv
// Property checker for bht_banked, attached with bind.
// It derives the trained entry number on its own from the update address and the parameters.
module bht_banked_chk
    import bht_pkg::*;
#(
    parameter int unsigned ENTRIES    = 64,
    parameter int unsigned SLOTS      = 2,
    parameter int unsigned ADDR_W     = 32,
    parameter bit          COMPRESSED = 1'b1,
    localparam int unsigned IDX_W     = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_i,
    input logic               upd_en_i,
    input logic [ADDR_W-1:0]  upd_pc_i,
    input logic               upd_taken_i,
    input logic [SLOTS-1:0]   lkp_valid_o,
    input logic [SLOTS-1:0]   lkp_taken_o,
    input logic [ENTRIES-1:0] vld_q,
    input ctr_t [ENTRIES-1:0] ctr_q
);

    localparam int unsigned OFS = COMPRESSED ? 1 : 2;

    // Row and column are adjacent, so the entry number is one contiguous field.
    logic [IDX_W-1:0] upd_idx;
    assign upd_idx = upd_pc_i[OFS +: IDX_W];

    logic trn;
    assign trn = upd_en_i && !flush_i;

    p_reset_clears_r9: assert property (@(posedge clk)
        !rst_n |=> (vld_q == '0));

    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (vld_q == '0));

    p_first_train_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trn && !vld_q[upd_idx]) |=>
            (vld_q[$past(upd_idx)] &&
             ctr_q[$past(upd_idx)] == ($past(upd_taken_i) ? 2'd2 : 2'd1)));

    p_inc_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trn && vld_q[upd_idx] && upd_taken_i) |=>
            (ctr_q[$past(upd_idx)] ==
             (($past(ctr_q[upd_idx]) == 2'd3) ? 2'd3 : $past(ctr_q[upd_idx]) + 2'd1)));

    p_dec_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trn && vld_q[upd_idx] && !upd_taken_i) |=>
            (ctr_q[$past(upd_idx)] ==
             (($past(ctr_q[upd_idx]) == 2'd0) ? 2'd0 : $past(ctr_q[upd_idx]) - 2'd1)));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en_i && !flush_i) |=> ($stable(vld_q) && $stable(ctr_q)));

    p_single_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i |=> ($countones(vld_q ^ $past(vld_q)) <= 1));

    p_taken_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((lkp_taken_o & ~lkp_valid_o) == '0));

endmodule

bind bht_banked bht_banked_chk #(
    .ENTRIES(ENTRIES), .SLOTS(SLOTS), .ADDR_W(ADDR_W), .COMPRESSED(COMPRESSED)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .upd_en_i    (upd_en_i),
    .upd_pc_i    (upd_pc_i),
    .upd_taken_i (upd_taken_i),
    .lkp_valid_o (lkp_valid_o),
    .lkp_taken_o (lkp_taken_o),
    .vld_q       (vld_q),
    .ctr_q       (ctr_q)
);

// File: tb/bht_banked_tb.sv
`timescale 1ns/1ps
module bht_banked_tb;

    localparam int ENT = 16;
    localparam int NS  = 2;
    localparam int AW  = 16;
    localparam realtime TCK = 20.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic upd_en = 1'b0;
    logic upd_tkn = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic [AW-1:0] lkp_pc = '0;
    logic [NS-1:0] a_vld, a_tkn, b_vld, b_tkn;

    int total = 0;
    int bad = 0;

    always #(TCK/2) clk = ~clk;

    // Instance with compressed support (offset 1 bit).
    bht_banked #(.ENTRIES(ENT), .SLOTS(NS), .ADDR_W(AW), .COMPRESSED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .lkp_pc_i(lkp_pc),
        .lkp_valid_o(a_vld), .lkp_taken_o(a_tkn),
        .upd_en_i(upd_en), .upd_pc_i(upd_pc), .upd_taken_i(upd_tkn));

    // Instance without compressed support (offset 2 bits).
    bht_banked #(.ENTRIES(ENT), .SLOTS(NS), .ADDR_W(AW), .COMPRESSED(1'b0)) u_dut_nc (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .lkp_pc_i(lkp_pc),
        .lkp_valid_o(b_vld), .lkp_taken_o(b_tkn),
        .upd_en_i(upd_en), .upd_pc_i(upd_pc), .upd_taken_i(upd_tkn));

    // Reference state: index 0 = compressed instance, 1 = the other.
    logic       rv [2][ENT];
    logic [1:0] rc [2][ENT];

    function automatic int ofs(int d);
        return (d == 0) ? 1 : 2;
    endfunction

    task automatic ref_clear();
        for (int d = 0; d < 2; d++)
            for (int e = 0; e < ENT; e++) begin
                rv[d][e] = 1'b0;
                rc[d][e] = 2'd0;
            end
    endtask

    task automatic ref_apply(input logic u, input logic t, input logic f, input logic [AW-1:0] pc);
        if (f) begin
            for (int d = 0; d < 2; d++)
                for (int e = 0; e < ENT; e++) rv[d][e] = 1'b0;
        end else if (u) begin
            for (int d = 0; d < 2; d++) begin
                int e;
                e = (int'(pc) >> ofs(d)) % ENT;
                if (!rv[d][e]) begin
                    rv[d][e] = 1'b1;
                    rc[d][e] = t ? 2'd2 : 2'd1;
                end else if (t) begin
                    if (rc[d][e] != 2'd3) rc[d][e] = rc[d][e] + 2'd1;
                end else begin
                    if (rc[d][e] != 2'd0) rc[d][e] = rc[d][e] - 2'd1;
                end
            end
        end
    endtask

    function automatic logic [3:0] ref_look(int d, logic [AW-1:0] pc);
        logic [1:0] v, k;
        int row;
        row = (int'(pc) >> (ofs(d) + 1)) % (ENT / NS);
        for (int s = 0; s < NS; s++) begin
            v[s] = rv[d][row*NS + s];
            k[s] = rv[d][row*NS + s] & rc[d][row*NS + s][1];
        end
        return {v, k};
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s pc=%h actual vld/tkn=%b expected=%b", req, lkp_pc, act, exp);
        end
    endtask

    // One clocked operation; inputs change at the falling edge.
    task automatic step(input logic u, input logic t, input logic f, input logic [AW-1:0] pc);
        @(negedge clk);
        upd_en = u; upd_tkn = t; flush = f; upd_pc = pc;
        @(posedge clk);
        ref_apply(u, t, f, pc);
        @(negedge clk);
        upd_en = 1'b0; flush = 1'b0;
    endtask

    task automatic look_both(input string req, input logic [AW-1:0] pc);
        lkp_pc = pc;
        #1;
        chk(req, {a_vld, a_tkn}, ref_look(0, pc));
        chk(req, {b_vld, b_tkn}, ref_look(1, pc));
    endtask

    task automatic sweep_empty(input string req);
        for (int p = 0; p < 64; p += 2) begin
            lkp_pc = AW'(p);
            #1;
            chk(req, {a_vld, a_tkn}, 4'b0000);
            chk(req, {b_vld, b_tkn}, 4'b0000);
        end
    endtask

    // Table for the compressed instance: {update, taken, pc[7:0], exp valid[1:0], exp taken[1:0]}.
    // Address layout there: bit0 offset, bit1 column, bits[4:2] row.
    localparam logic [13:0] VEC [14] = '{
        {1'b1, 1'b1, 8'h00, 2'b01, 2'b01},  // R4 first train taken -> 2
        {1'b1, 1'b1, 8'h00, 2'b01, 2'b01},  // R5 -> 3
        {1'b1, 1'b1, 8'h00, 2'b01, 2'b01},  // R5 saturate at 3
        {1'b1, 1'b0, 8'h00, 2'b01, 2'b01},  // R5 -> 2
        {1'b1, 1'b0, 8'h00, 2'b01, 2'b00},  // R3 -> 1 not taken
        {1'b1, 1'b0, 8'h00, 2'b01, 2'b00},  // -> 0
        {1'b1, 1'b0, 8'h00, 2'b01, 2'b00},  // R5 saturate at 0
        {1'b1, 1'b1, 8'h00, 2'b01, 2'b00},  // -> 1
        {1'b1, 1'b0, 8'h02, 2'b11, 2'b00},  // R4 column 1 first train not taken -> 1
        {1'b1, 1'b1, 8'h03, 2'b11, 2'b10},  // R10 offset bit ignored -> 2
        {1'b1, 1'b1, 8'h1E, 2'b10, 2'b10},  // R1 row 7 column 1
        {1'b1, 1'b0, 8'hE2, 2'b11, 2'b00},  // R10 high bits ignored, row 0 column 1 -> 1
        {1'b0, 1'b0, 8'h1C, 2'b10, 2'b10},  // R2 lookup only, row 7
        {1'b0, 1'b0, 8'h04, 2'b00, 2'b00}   // R7 untouched row 1
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        ref_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state: everything invalid.
        sweep_empty("R9 reset state");

        // Table walk.
        for (int i = 0; i < 14; i++) begin
            step(VEC[i][13], VEC[i][12], 1'b0, AW'(VEC[i][11:4]));
            lkp_pc = AW'(VEC[i][11:4]);
            #1;
            chk("R1 R2 R3 R4 R5 table", {a_vld, a_tkn}, VEC[i][3:0]);
            chk("R1 reference", {b_vld, b_tkn}, ref_look(1, lkp_pc));
        end

        // R6: a lookup of the entry being trained sees the old state in that cycle.
        @(negedge clk);
        upd_en = 1'b1; upd_tkn = 1'b1; upd_pc = 16'h0008; lkp_pc = 16'h0008;
        #1;
        chk("R6 same-cycle old value", {a_vld, a_tkn}, 4'b0000);
        @(posedge clk);
        ref_apply(1'b1, 1'b1, 1'b0, 16'h0008);
        @(negedge clk);
        upd_en = 1'b0;
        #1;
        chk("R6 visible after edge", {a_vld, a_tkn}, 4'b0101);

        // R8: flush together with an update leaves the trained entry invalid.
        step(1'b1, 1'b1, 1'b1, 16'h0004);
        lkp_pc = 16'h0004;
        #1;
        chk("R8 flush beats update", {a_vld, a_tkn}, 4'b0000);
        sweep_empty("R8 flush clears all");

        // Random phase against the reference model, both offset settings.
        for (int n = 0; n < 400; n++) begin
            logic u, t, f;
            u = ($urandom % 4) != 0;
            t = $urandom % 2;
            f = ($urandom % 32) == 0;
            step(u, t, f, AW'($urandom));
            look_both("R1 R5 R7 R8 R10 random", AW'($urandom));
            look_both("R2 R6 random", upd_pc);
        end

        // R9: reset in the middle of operation.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        ref_clear();
        @(negedge clk);
        rst_n = 1'b1;
        sweep_empty("R9 mid-run reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule